// File: doc/BRIEF.md
# Microcoded Control Sequencer for an Accumulator CPU

This block is the control unit of a small accumulator processor. A step register moves through five microsteps per instruction. A combinational microcode decoder turns the held opcode, the current step and the carry and zero flags into a word of sixteen control strobes. The strobes drive the datapath: program counter, memory address register, RAM, instruction register, A and B registers, ALU, flags and output register. The datapath itself sits outside this block. Every instruction begins with the same two fetch steps. The three execute steps that follow depend on the opcode. A conditional jump is handled by choosing between two execute rows on the matching flag.

The step register is a state machine with five named states. FETCH_ADDR (000) goes to FETCH_READ (001), then EXEC_A (010), then EXEC_B (011), then EXEC_C (100), and from there back to FETCH_ADDR. Two events override this order. A synchronous reset forces FETCH_ADDR from any state. A halt strobe in the current control word holds the current state. A one-hot T-state vector gives the step in decoded form.

Top module: `cpu_ctrl_seq`

## Requirements
- R1: With rst_i high at a rising clock edge, step_o becomes 000 and tstate_o becomes 00001, whatever state the sequencer was in.
- R2: Without reset and without halt, step_o advances by one on each rising edge: 000, 001, 010, 011, 100, then 000 again.
- R3: tstate_o always has exactly one bit set, and that bit's index equals step_o.
- R4: Bit positions of ctrl_o: 0 pc_drive, 1 mar_load, 2 ram_drive, 3 ir_load, 4 pc_inc, 5 ir_drive, 6 a_load, 7 b_load, 8 alu_drive, 9 alu_sub, 10 flag_load, 11 a_drive, 12 ram_load, 13 pc_jump, 14 out_load, 15 halt. At most one of the bus-driving bits (0, 2, 5, 8, 11) is set at a time.
- R5: For any opcode and flags, step 000 gives ctrl_o = 0x0003 and step 001 gives ctrl_o = 0x001C.
- R6: LDA (0001) gives 0x0022, 0x0044, 0x0000 in steps 010, 011, 100. STA (0100) gives 0x0022, 0x1800, 0x0000.
- R7: ADD (0010) gives 0x0022, 0x0084, 0x0540 in steps 010, 011, 100. SUB (0011) gives the same, except 0x0740 at step 100.
- R8: LDI (0101) gives 0x0060 at step 010. JMP (0110) gives 0x2020 at step 010. OUT (1110) gives 0x4800 at step 010. All three give 0x0000 in steps 011 and 100.
- R9: JC (0111) gives 0x2020 at step 010 when carry_i is 1 and 0x0000 when it is 0. Steps 011 and 100 give 0x0000.
- R10: JZ (1000) gives 0x2020 at step 010 when zero_i is 1 and 0x0000 when it is 0. Steps 011 and 100 give 0x0000.
- R11: HLT (1111) gives 0x8000 at step 010. While halt is set, step_o keeps its value on every edge until reset.
- R12: NOP (0000) and the unused opcodes 1001 to 1101 give 0x0000 in steps 010 to 100. The flags have no effect on any opcode other than JC and JZ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| opcode_i | input | 4 | Opcode from the instruction register |
| carry_i | input | 1 | Carry flag |
| zero_i | input | 1 | Zero flag |
| ctrl_o | output | 16 | Control strobe word (bit map in R4) |
| step_o | output | 3 | Binary microstep |
| tstate_o | output | 5 | One-hot microstep |

## Verification
The hardest state to reach from the ports is a step counter that stays frozen by its own halt output. Reaching it requires the HLT opcode to be held through fetch into step 010, and that step in turn requires five-cycle alignment from reset. The bench keeps its own model of the step, applies HLT across a whole instruction, and then checks several further edges with no movement. It then releases the counter with a reset in the middle of an instruction and confirms both the restart and the realignment. The flag-selected jump rows are covered with both flag values, and the other opcodes are covered with the flags toggled.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;

    localparam int STEP_W    = 3;
    localparam int NUM_STEPS = 5;
    localparam int OP_W      = 4;
    localparam int CTRL_W    = 16;

    typedef enum logic [STEP_W-1:0] {
        ST_FETCH_ADDR = 3'd0,
        ST_FETCH_READ = 3'd1,
        ST_EXEC_A     = 3'd2,
        ST_EXEC_B     = 3'd3,
        ST_EXEC_C     = 3'd4
    } step_e;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 4'b0000,
        OP_LDA = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0011,
        OP_STA = 4'b0100,
        OP_LDI = 4'b0101,
        OP_JMP = 4'b0110,
        OP_JC  = 4'b0111,
        OP_JZ  = 4'b1000,
        OP_OUT = 4'b1110,
        OP_HLT = 4'b1111
    } opcode_e;

    // First field is the most significant bit.
    typedef struct packed {
        logic halt;
        logic out_load;
        logic pc_jump;
        logic ram_load;
        logic a_drive;
        logic flag_load;
        logic alu_sub;
        logic alu_drive;
        logic b_load;
        logic a_load;
        logic ir_drive;
        logic pc_inc;
        logic ir_load;
        logic ram_drive;
        logic mar_load;
        logic pc_drive;
    } ctrl_t;

endpackage

// File: rtl/seq_step_counter.sv
module seq_step_counter
    import cpu_seq_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  hold_i,
    output step_e step_o
);

    step_e state_q;
    step_e state_d;

    always_comb begin
        state_d = state_q;
        if (!hold_i) begin
            unique case (state_q)
                ST_FETCH_ADDR: state_d = ST_FETCH_READ;
                ST_FETCH_READ: state_d = ST_EXEC_A;
                ST_EXEC_A:     state_d = ST_EXEC_B;
                ST_EXEC_B:     state_d = ST_EXEC_C;
                ST_EXEC_C:     state_d = ST_FETCH_ADDR;
                default:       state_d = ST_FETCH_ADDR;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_FETCH_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    assign step_o = state_q;

endmodule

// File: rtl/seq_microcode_dec.sv
module seq_microcode_dec
    import cpu_seq_pkg::*;
(
    input  step_e           step_i,
    input  logic [OP_W-1:0] opcode_i,
    input  logic            carry_i,
    input  logic            zero_i,
    output ctrl_t           ctrl_o
);

    ctrl_t exec_a;
    ctrl_t exec_b;
    ctrl_t exec_c;

    // First execute step.
    always_comb begin
        exec_a = '0;
        case (opcode_i)
            OP_LDA, OP_ADD, OP_SUB, OP_STA: begin
                exec_a.ir_drive = 1'b1;
                exec_a.mar_load = 1'b1;
            end
            OP_LDI: begin
                exec_a.ir_drive = 1'b1;
                exec_a.a_load   = 1'b1;
            end
            OP_JMP: begin
                exec_a.ir_drive = 1'b1;
                exec_a.pc_jump  = 1'b1;
            end
            OP_JC: begin
                exec_a.ir_drive = carry_i;
                exec_a.pc_jump  = carry_i;
            end
            OP_JZ: begin
                exec_a.ir_drive = zero_i;
                exec_a.pc_jump  = zero_i;
            end
            OP_OUT: begin
                exec_a.a_drive  = 1'b1;
                exec_a.out_load = 1'b1;
            end
            OP_HLT: begin
                exec_a.halt = 1'b1;
            end
            default: exec_a = '0;
        endcase
    end

    // Second execute step.
    always_comb begin
        exec_b = '0;
        case (opcode_i)
            OP_LDA: begin
                exec_b.ram_drive = 1'b1;
                exec_b.a_load    = 1'b1;
            end
            OP_ADD, OP_SUB: begin
                exec_b.ram_drive = 1'b1;
                exec_b.b_load    = 1'b1;
            end
            OP_STA: begin
                exec_b.a_drive  = 1'b1;
                exec_b.ram_load = 1'b1;
            end
            default: exec_b = '0;
        endcase
    end

    // Third execute step.
    always_comb begin
        exec_c = '0;
        case (opcode_i)
            OP_ADD: begin
                exec_c.alu_drive = 1'b1;
                exec_c.a_load    = 1'b1;
                exec_c.flag_load = 1'b1;
            end
            OP_SUB: begin
                exec_c.alu_drive = 1'b1;
                exec_c.alu_sub   = 1'b1;
                exec_c.a_load    = 1'b1;
                exec_c.flag_load = 1'b1;
            end
            default: exec_c = '0;
        endcase
    end

    // Row selection by step.
    always_comb begin
        ctrl_o = '0;
        unique case (step_i)
            ST_FETCH_ADDR: begin
                ctrl_o.pc_drive = 1'b1;
                ctrl_o.mar_load = 1'b1;
            end
            ST_FETCH_READ: begin
                ctrl_o.ram_drive = 1'b1;
                ctrl_o.ir_load   = 1'b1;
                ctrl_o.pc_inc    = 1'b1;
            end
            ST_EXEC_A: ctrl_o = exec_a;
            ST_EXEC_B: ctrl_o = exec_b;
            ST_EXEC_C: ctrl_o = exec_c;
            default:   ctrl_o = '0;
        endcase
    end

endmodule

// File: rtl/seq_tstate_onehot.sv
module seq_tstate_onehot
    import cpu_seq_pkg::*;
(
    input  step_e                step_i,
    output logic [NUM_STEPS-1:0] tstate_o
);

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_ts
        assign tstate_o[g] = (step_i == STEP_W'(g));
    end

endmodule

// File: rtl/cpu_ctrl_seq.sv
module cpu_ctrl_seq
    import cpu_seq_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [OP_W-1:0]      opcode_i,
    input  logic                 carry_i,
    input  logic                 zero_i,
    output logic [CTRL_W-1:0]    ctrl_o,
    output logic [STEP_W-1:0]    step_o,
    output logic [NUM_STEPS-1:0] tstate_o
);

    step_e step_s;
    ctrl_t ctrl_s;

    seq_step_counter u_cnt (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .hold_i (ctrl_s.halt),
        .step_o (step_s)
    );

    seq_microcode_dec u_dec (
        .step_i   (step_s),
        .opcode_i (opcode_i),
        .carry_i  (carry_i),
        .zero_i   (zero_i),
        .ctrl_o   (ctrl_s)
    );

    seq_tstate_onehot u_ts (
        .step_i   (step_s),
        .tstate_o (tstate_o)
    );

    assign ctrl_o = ctrl_s;
    assign step_o = step_s;

endmodule

// File: rtl/cpu_ctrl_seq_chk.sv
module cpu_ctrl_seq_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic [3:0]  opcode_i,
    input logic        carry_i,
    input logic        zero_i,
    input logic [15:0] ctrl_o,
    input logic [2:0]  step_o,
    input logic [4:0]  tstate_o
);

    logic [4:0] bus_drv;
    assign bus_drv = {ctrl_o[11], ctrl_o[8], ctrl_o[5], ctrl_o[2], ctrl_o[0]};

    assert_reset_step_R1: assert property (@(posedge clk_i)
        rst_i |=> (step_o == 3'd0));

    assert_advance_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ctrl_o[15] && step_o < 3'd4) |=> (step_o == $past(step_o) + 3'd1));

    assert_wrap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ctrl_o[15] && step_o == 3'd4) |=> (step_o == 3'd0));

    assert_tstate_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(tstate_o) && (tstate_o == (5'b00001 << step_o)));

    assert_one_driver_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(bus_drv));

    assert_fetch_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_o == 3'd0) |-> (ctrl_o == 16'h0003));

    assert_jc_not_taken_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_o == 3'd2 && opcode_i == 4'b0111 && !carry_i) |-> (ctrl_o == 16'h0000));

    assert_jz_not_taken_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_o == 3'd2 && opcode_i == 4'b1000 && !zero_i) |-> (ctrl_o == 16'h0000));

    assert_halt_hold_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl_o[15] |=> $stable(step_o));

endmodule

bind cpu_ctrl_seq cpu_ctrl_seq_chk chk_i (.*);

// File: tb/cpu_ctrl_seq_tb_top.sv
module cpu_ctrl_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic [3:0]  opcode_i = 4'd0;
    logic        carry_i = 1'b0;
    logic        zero_i = 1'b0;
    logic [15:0] ctrl_o;
    logic [2:0]  step_o;
    logic [4:0]  tstate_o;

    always #10 clk = ~clk;  // 50 MHz

    cpu_ctrl_seq dut_i (
        .clk_i    (clk),
        .rst_i    (rst_i),
        .opcode_i (opcode_i),
        .carry_i  (carry_i),
        .zero_i   (zero_i),
        .ctrl_o   (ctrl_o),
        .step_o   (step_o),
        .tstate_o (tstate_o)
    );

    typedef struct {
        logic [2:0]  step;
        logic [4:0]  ts;
        logic [15:0] ctrl;
        string       ctag;
        string       stag;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [2:0] exp_step = 3'd0;
    bit after_rst = 1'b0;

    // R4: values below use the bit map of R4.
    function automatic logic [15:0] exp_ctrl(logic [2:0] s, logic [3:0] op, logic c, logic z);
        if (s == 3'd0) return 16'h0003;
        if (s == 3'd1) return 16'h001C;
        case (op)
            4'b0001: return (s == 3'd2) ? 16'h0022 : (s == 3'd3) ? 16'h0044 : 16'h0000;
            4'b0010: return (s == 3'd2) ? 16'h0022 : (s == 3'd3) ? 16'h0084 : 16'h0540;
            4'b0011: return (s == 3'd2) ? 16'h0022 : (s == 3'd3) ? 16'h0084 : 16'h0740;
            4'b0100: return (s == 3'd2) ? 16'h0022 : (s == 3'd3) ? 16'h1800 : 16'h0000;
            4'b0101: return (s == 3'd2) ? 16'h0060 : 16'h0000;
            4'b0110: return (s == 3'd2) ? 16'h2020 : 16'h0000;
            4'b0111: return (s == 3'd2 && c) ? 16'h2020 : 16'h0000;
            4'b1000: return (s == 3'd2 && z) ? 16'h2020 : 16'h0000;
            4'b1110: return (s == 3'd2) ? 16'h4800 : 16'h0000;
            4'b1111: return (s == 3'd2) ? 16'h8000 : 16'h0000;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string ctag_of(logic [2:0] s, logic [3:0] op);
        if (s < 3'd2) return "R5";
        case (op)
            4'b0001, 4'b0100: return "R6";
            4'b0010, 4'b0011: return "R7";
            4'b0101, 4'b0110, 4'b1110: return "R8";
            4'b0111: return "R9";
            4'b1000: return "R10";
            4'b1111: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic drive_cycle(input logic [3:0] op, input logic c, input logic z);
        item_t it;
        logic [15:0] ec;
        @(negedge clk);
        opcode_i = op;
        carry_i  = c;
        zero_i   = z;
        ec = exp_ctrl(exp_step, op, c, z);
        it.step = exp_step;
        it.ts   = 5'b00001 << exp_step;
        it.ctrl = ec;
        it.ctag = ctag_of(exp_step, op);
        it.stag = after_rst ? "R1" : (ec[15] ? "R11" : "R2");
        after_rst = 1'b0;
        q.push_back(it);
        if (!ec[15]) exp_step = (exp_step == 3'd4) ? 3'd0 : exp_step + 3'd1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_i = 1'b0;
        exp_step = 3'd0;
        after_rst = 1'b1;
        // The driver's next negedge is the following one; keep alignment by
        // re-entering on this same edge.
        begin
            item_t it;
            it.step = 3'd0;
            it.ts   = 5'b00001;
            it.ctrl = 16'h0003;
            it.ctag = "R5";
            it.stag = "R1";
            q.push_back(it);
            after_rst = 1'b0;
            exp_step = 3'd1;
        end
    endtask

    task automatic run_instr(input logic [3:0] op, input logic c, input logic z);
        for (int k = 0; k < 5; k++) drive_cycle(op, c, z);
    endtask

    // Monitor: sample a quarter period after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q.size() != 0) begin
                item_t it;
                it = q.pop_front();
                n_cmp++;
                if (step_o !== it.step) begin
                    n_bad++;
                    $display("FAIL %s step: actual %0d expected %0d", it.stag, step_o, it.step);
                end
                n_cmp++;
                if (tstate_o !== it.ts) begin
                    n_bad++;
                    $display("FAIL R3 tstate: actual %b expected %b", tstate_o, it.ts);
                end
                n_cmp++;
                if (ctrl_o !== it.ctrl) begin
                    n_bad++;
                    $display("FAIL %s ctrl (step %0d op %b): actual %h expected %h",
                             it.ctag, it.step, opcode_i, ctrl_o, it.ctrl);
                end
            end
        end
    end

    // Driver: stimulus sequence.
    initial begin
        do_reset();                        // R1, then step 000 remains
        // finish the first instruction as NOP from step 001
        for (int k = 0; k < 4; k++) drive_cycle(4'b0000, 1'b1, 1'b1);
        run_instr(4'b0001, 1'b0, 1'b0);    // R6 LDA
        run_instr(4'b0100, 1'b1, 1'b0);    // R6 STA
        run_instr(4'b0010, 1'b0, 1'b0);    // R7 ADD
        run_instr(4'b0010, 1'b1, 1'b1);    // R12 flags ignored
        run_instr(4'b0011, 1'b0, 1'b1);    // R7 SUB
        run_instr(4'b0101, 1'b1, 1'b1);    // R8 LDI
        run_instr(4'b0110, 1'b0, 1'b0);    // R8 JMP
        run_instr(4'b1110, 1'b1, 1'b0);    // R8 OUT
        run_instr(4'b0111, 1'b0, 1'b1);    // R9 not taken
        run_instr(4'b0111, 1'b1, 1'b0);    // R9 taken
        run_instr(4'b1000, 1'b1, 1'b0);    // R10 not taken
        run_instr(4'b1000, 1'b0, 1'b1);    // R10 taken
        for (int op = 9; op <= 13; op++)   // R12 unused opcodes
            run_instr(4'(op), op[0], op[1]);
        run_instr(4'b0000, 1'b1, 1'b0);    // R12 NOP
        // R5: opcode changes every cycle across several instructions
        for (int k = 0; k < 25; k++)
            drive_cycle(4'((k * 7 + 3) % 16 == 15 ? 0 : (k * 7 + 3) % 16), k[0], k[1]);
        // realign: exp_step is 0 after 25 cycles
        // R11: halt freezes the step at 010
        for (int k = 0; k < 12; k++) drive_cycle(4'b1111, k[0], k[1]);
        // R1: reset releases halt
        do_reset();
        for (int k = 0; k < 2; k++) drive_cycle(4'b0001, 1'b0, 1'b0);
        // R1: reset in the middle of an instruction (step 011)
        do_reset();
        for (int k = 0; k < 4; k++) drive_cycle(4'b0011, 1'b1, 1'b1);
        run_instr(4'b0100, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(20 * 200000);
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule